// File: doc/BRIEF.md
# Retransmitting Nine-Bit FIFO Buffer

This block is a first-in/first-out buffer for 9-bit words: eight data bits plus one bit that the user may spend on parity or control. Storage is a dual-port array whose write and read locations come from two internal ring pointers that advance by one and wrap. The user port has no address inputs. A write strobe and a read strobe are sampled on the same clock and may both be active in one cycle. Three active-low status outputs report when the buffer is empty, when it is full, and when it holds more than half its depth.

An active-low rewind input sends the read pointer back to location zero. The words written since reset can then be read again from the first one. The occupancy is reloaded from the write pointer, and the flags follow the new occupancy. This is intended for the retry of a frame that has not yet filled the buffer. The depth is a power-of-two parameter from 512 to 16384 words.

Top module: `fifo9_rt`

## Requirements
- R1: While `rst_n` is low, both pointers and the occupancy return to zero and `rd_data` is cleared. After reset, `empty_n` is 0, `full_n` is 1 and `half_n` is 1.
- R2: Words come out in the order they were accepted, with all 9 bits intact. `rd_data` takes the word at the read pointer on the clock edge that accepts a read, and holds its value in every other cycle.
- R3: When neither blocking flag is active, a write and a read in the same cycle are both accepted and the occupancy is unchanged.
- R4: `full_n` is 0 exactly when the occupancy equals DEPTH. A write strobe in that state is ignored, and no stored word is overwritten.
- R5: `empty_n` is 0 exactly when the occupancy is zero. A read strobe in that state is ignored, and the read pointer and `rd_data` keep their values.
- R6: `half_n` is 0 when the occupancy is DEPTH/2+1 or more, and 1 when it is DEPTH/2 or less.
- R7: A clock edge with `rtx_n` low sets the read pointer to location 0 and the occupancy to the write-pointer position. The flags are valid for that occupancy after the same edge. Write and read strobes in that cycle are ignored.
- R8: Both pointers wrap from DEPTH-1 to 0, and ordering and flags stay correct across the wrap.
- R9: When full, a simultaneous write and read performs only the read. When empty, a simultaneous write and read performs only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read strobe |
| rtx_n | input | 1 | Active-low rewind of the read pointer |
| rd_data | output | 9 | Last word read |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The assertions assume that the rewind input is asserted only while fewer than DEPTH words have been written since reset. Past that point the write-pointer position no longer equals the count of words still to be replayed. The stimulus issues its single rewind after 300 writes into a 512-word buffer, so it stays inside that limit. Every later phase, including the wrap of both pointers, runs without a rewind. Strobes are driven on the falling edge, so they are always stable at the sampling edge.

// File: rtl/fifo9_rt.sv
module fifo9_rt #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rtx_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  initial begin
    if ((1 << AW) != DEPTH || DEPTH < 512 || DEPTH > 16384)
      $error("fifo9_rt: DEPTH must be a power of two in 512..16384");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      count;

  wire push = wr_en && full_n  && rtx_n;
  wire pop  = rd_en && empty_n && rtx_n;

  assign empty_n = (count != '0);
  assign full_n  = (count != FULL_CNT);
  assign half_n  = !(count > HALF_CNT);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_data <= '0;
    end else if (!rtx_n) begin
      rptr  <= '0;
      count <= {1'b0, wptr};
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && wr_en && !rd_en && rtx_n) |=> (count == FULL_CNT && $stable(wptr)));

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rd_en && rtx_n) |=> ($stable(rptr) && $stable(rd_data)));

  p_concurrent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rtx_n && wr_en && rd_en && empty_n && full_n) |=> $stable(count));

  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtx_n) |=> (rptr == '0 && count == {1'b0, $past(wptr)}));

  p_half_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(half_n) && $past(rtx_n)) |-> (count == HALF_CNT + 1'b1));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

endmodule

// File: tb/fifo9_rt_test.sv
`timescale 1ns/1ps
module fifo9_rt_test;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, rtx_n;
  logic [8:0] wr_data, rd_data;
  logic empty_n, full_n, half_n;

  always #4 clk = ~clk;

  fifo9_rt #(.DEPTH(DEPTH), .WIDTH(9)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rtx_n(rtx_n), .rd_data(rd_data),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  int checks = 0, fails = 0;
  logic [8:0] mm [DEPTH];
  int wp = 0, rp = 0, cnt = 0, wtot = 0, seq = 0;
  logic [8:0] expq = '0;

  function automatic logic [8:0] word(input int n);
    return 9'((n * 151 + 7) ^ (n >>> 3));
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "rd_data", int'(rd_data), int'(expq));
    chk(tag, "empty_n", int'(empty_n), int'(cnt != 0));
    chk(tag, "full_n",  int'(full_n),  int'(cnt != DEPTH));
    chk(tag, "half_n",  int'(half_n),  int'(!(cnt > HALF)));
  endtask

  task automatic step(input logic we, input logic re, input logic rt, input string tag);
    logic [8:0] d;
    bit p, q;
    d = word(seq);
    seq++;
    if (rt) begin
      rp = 0;
      cnt = wtot;
    end else begin
      p = we && (cnt < DEPTH);
      q = re && (cnt > 0);
      if (q) begin expq = mm[rp]; rp = (rp + 1) % DEPTH; end
      if (p) begin mm[wp] = d; wp = (wp + 1) % DEPTH; wtot++; end
      cnt = cnt + int'(p) - int'(q);
    end
    wr_en = we; wr_data = d; rd_en = re; rtx_n = !rt;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rtx_n = 1'b1; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // reads on empty are ignored
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, "R5");

    // fill past the midpoint, half flag at each count
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 10; i++)  step(1'b0, 1'b1, 1'b0, "R2");

    // rewind with strobes active: strobes ignored
    step(1'b1, 1'b1, 1'b1, "R7");
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, "R5");

    // fill to full across the wrap, then push against full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b0, "R9");

    for (int i = 0; i < 256; i++) step(1'b0, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1'b0, "R3");
    while (cnt > 0) step(1'b0, 1'b1, 1'b0, "R8");

    // empty with both strobes: write only
    step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, "R5");

    wr_en = 1'b0; rd_en = 1'b0; rtx_n = 1'b1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule